// File: doc/BRIEF.md
# Dual-Channel DAC Serial Input Register

This block is the receiving side of a two-channel, 16-bit DAC with a serial load port. A host shifts 24-bit words in over three wires: an active-low frame select, a serial clock and a data line. The block runs on its own system clock and first brings the three wires into that domain through synchronisers. It then counts falling serial-clock edges while the frame select is low. Once 24 bits have arrived, it decodes the word.

Each channel holds a data buffer, a DAC register and a power-mode field. The upper eight bits of a word carry the command. These bits pick the channel, its power mode, and whether the word only fills that channel's buffer, also moves it into that channel's DAC register, or refreshes both DAC registers together from their buffers. A host can therefore change one output at a time, or stage channel A and then change both outputs on the same cycle with the channel B word.

A frame cut short by the frame select returning high is dropped and changes nothing.

Top module: `dac2_serial_rx`

## Requirements
- R1: Data is captured on falling edges of `sclk_i` while `sync_n_i` is low, most significant bit first. The word is decoded once the 24th falling edge has arrived.
- R2: When `rst` is high, both buffers and both DAC registers clear to zero and both power modes return to 00. The first update after reset sees the other channel's buffer as zero.
- R3: If `sync_n_i` goes high before 24 bits have arrived, the partial word is dropped. No buffer, DAC register or power mode changes, and the next frame starts from bit zero.
- R4: Serial clocks after the 24th in the same low period of `sync_n_i` are ignored until `sync_n_i` goes high and then low again.
- R5: A load command (word bits 21:20) of 00 or 10 writes only the selected channel's buffer and leaves both DAC registers unchanged.
- R6: Load command 01 writes the selected channel's buffer and DAC register, and leaves the other channel's DAC register unchanged.
- R7: Load command 11 writes the selected channel's buffer. In the same cycle it loads both DAC registers: the selected one with the new code, the other with its own buffer.
- R8: Word bit 18 selects the channel: 0 is channel A (`dac_a_o`, `pwr_a_o`) and 1 is channel B (`dac_b_o`, `pwr_b_o`).
- R9: Word bits 17:16 are stored as the selected channel's power mode on every completed frame. 00 means normal operation and 01, 10 and 11 mean three power-down modes. The other channel's mode is unchanged.
- R10: Word bits 23:22 and 19 are ignored.
- R11: Frames are received correctly when the system clock runs as little as four times faster than the serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n_i | input | 1 | Active-low frame select from host |
| sclk_i | input | 1 | Serial clock from host, data taken on falling edge |
| din_i | input | 1 | Serial data from host |
| dac_a_o | output | 16 | Channel A DAC register |
| dac_b_o | output | 16 | Channel B DAC register |
| pwr_a_o | output | 2 | Channel A power mode |
| pwr_b_o | output | 2 | Channel B power mode |

## Verification
Wrong internal state in this block usually shows up later, not at once. A wrong bit count or a shift register left uncleared after an aborted frame shows up only on the next frame that completes: every field lands one or more bits off, so both the code and the command are corrupted. A stale buffer does not move any output until a load command 11 copies it into the other channel's DAC register. For that reason the bench stages buffers with buffer-only words and then reveals them with a later joint update. Extra clocks and truncated frames are each followed by a clean frame, so that a counter left in a bad state is caught within one frame time.

// File: rtl/dac2_pkg.sv
package dac2_pkg;

    localparam int DATA_W  = 16;
    localparam int CTRL_W  = 8;
    localparam int FRAME_W = CTRL_W + DATA_W;
    localparam int CHSEL_W = 1;
    localparam int NCH     = 1 << CHSEL_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        LD_BUF_0 = 2'b00,
        LD_NOW   = 2'b01,
        LD_BUF_1 = 2'b10,
        LD_ALL   = 2'b11
    } load_e;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'b00,
        PWR_OFF1 = 2'b01,
        PWR_OFF2 = 2'b10,
        PWR_OFF3 = 2'b11
    } pwr_e;

    typedef struct packed {
        logic [1:0]         rsv_hi;
        load_e              load;
        logic               rsv_mid;
        logic [CHSEL_W-1:0] chan;
        pwr_e               pwr;
        logic [DATA_W-1:0]  code;
    } frame_t;

    // does this channel's DAC register take a value for this command
    function automatic logic dac_loads(load_e cmd, logic sel);
        return (cmd == LD_ALL) || ((cmd == LD_NOW) && sel);
    endfunction

endpackage

// File: rtl/dac2_in_sync.sv
module dac2_in_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
        end else begin
            pipe_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dac2_frame_shift.sv
module dac2_frame_shift
    import dac2_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fs_n,
    input  logic   sck,
    input  logic   sdi,
    output logic   frm_vld_o,
    output frame_t frm_o
);
    logic               sck_q;
    logic               sck_fall;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               full_q;
    logic [FRAME_W-1:0] next_word;

    assign sck_fall  = sck_q && !sck;
    assign next_word = {shreg_q[FRAME_W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b1;
            shreg_q   <= '0;
            cnt_q     <= '0;
            full_q    <= 1'b0;
            frm_vld_o <= 1'b0;
            frm_o     <= '0;
        end else begin
            sck_q     <= sck;
            frm_vld_o <= 1'b0;
            if (fs_n) begin
                shreg_q <= '0;
                cnt_q   <= '0;
                full_q  <= 1'b0;
            end else if (sck_fall && !full_q) begin
                shreg_q <= next_word;
                if (cnt_q == CNT_W'(FRAME_W - 1)) begin
                    cnt_q     <= '0;
                    full_q    <= 1'b1;
                    frm_vld_o <= 1'b1;
                    frm_o     <= frame_t'(next_word);
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dac2_reg_bank.sv
module dac2_reg_bank
    import dac2_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        frm_vld,
    input  load_e                       load,
    input  logic [CHSEL_W-1:0]          chan,
    input  pwr_e                        pwr,
    input  logic [DATA_W-1:0]           code,
    output logic [NCH-1:0][DATA_W-1:0]  dac_o,
    output logic [NCH-1:0][1:0]         pwr_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic              sel;
        logic [DATA_W-1:0] buf_q;
        logic [DATA_W-1:0] dac_q;
        pwr_e              pwr_q;

        assign sel = (chan == CHSEL_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                buf_q <= '0;
                dac_q <= '0;
                pwr_q <= PWR_RUN;
            end else if (frm_vld) begin
                if (sel) begin
                    buf_q <= code;
                    pwr_q <= pwr;
                end
                if (dac_loads(load, sel)) begin
                    dac_q <= sel ? code : buf_q;
                end
            end
        end

        assign dac_o[c] = dac_q;
        assign pwr_o[c] = pwr_q;
    end
endmodule

// File: rtl/dac2_serial_rx.sv
module dac2_serial_rx
    import dac2_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_n_i,
    input  logic              sclk_i,
    input  logic              din_i,
    output logic [DATA_W-1:0] dac_a_o,
    output logic [DATA_W-1:0] dac_b_o,
    output logic [1:0]        pwr_a_o,
    output logic [1:0]        pwr_b_o
);
    logic [2:0]                 pins_s;
    logic                       fs_s;
    logic                       sck_s;
    logic                       sdi_s;
    logic                       frm_vld;
    frame_t                     frm;
    logic [NCH-1:0][DATA_W-1:0] dac_all;
    logic [NCH-1:0][1:0]        pwr_all;
    logic                       unused_rsv;

    dac2_in_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i ({sync_n_i, sclk_i, din_i}),
        .q_o (pins_s)
    );

    assign {fs_s, sck_s, sdi_s} = pins_s;

    dac2_frame_shift shift_i (
        .clk       (clk),
        .rst       (rst),
        .fs_n      (fs_s),
        .sck       (sck_s),
        .sdi       (sdi_s),
        .frm_vld_o (frm_vld),
        .frm_o     (frm)
    );

    dac2_reg_bank bank_i (
        .clk     (clk),
        .rst     (rst),
        .frm_vld (frm_vld),
        .load    (frm.load),
        .chan    (frm.chan),
        .pwr     (frm.pwr),
        .code    (frm.code),
        .dac_o   (dac_all),
        .pwr_o   (pwr_all)
    );

    assign unused_rsv = ^{frm.rsv_hi, frm.rsv_mid};

    assign dac_a_o = dac_all[0];
    assign dac_b_o = dac_all[1];
    assign pwr_a_o = pwr_all[0];
    assign pwr_b_o = pwr_all[1];
endmodule

// File: rtl/dac2_serial_rx_chk.sv
module dac2_serial_rx_chk
    import dac2_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fs_s,
    input logic              frm_vld,
    input frame_t            frm,
    input logic [DATA_W-1:0] dac_a,
    input logic [DATA_W-1:0] dac_b,
    input logic [1:0]        pwr_a,
    input logic [1:0]        pwr_b
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R2: state after a reset cycle
    always_ff @(posedge clk) begin
        if (rst_d === 1'b1) begin
            a_r2_reset_clear: assert (dac_a == '0 && dac_b == '0 && pwr_a == 2'b00 && pwr_b == 2'b00)
                else $error("R2 reset state wrong");
        end
    end

    // R3: no frame completes while frame select is high
    a_r3_no_frame_when_idle: assert property (@(posedge clk) disable iff (rst)
        fs_s |=> !frm_vld);

    // R3: outputs only move on a completed frame
    a_r3_hold_without_frame: assert property (@(posedge clk) disable iff (rst)
        !frm_vld |=> ($stable(dac_a) && $stable(dac_b) && $stable(pwr_a) && $stable(pwr_b)));

    // R4: a frame is reported once
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        frm_vld |=> !frm_vld);

    // R5: buffer-only commands leave DAC registers alone
    a_r5_buffer_only: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && !frm.load[0]) |=> ($stable(dac_a) && $stable(dac_b)));

    // R6: immediate update, channel A and channel B
    a_r6_now_a: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && frm.load == LD_NOW && frm.chan == 1'b0) |=> (dac_a == $past(frm.code) && $stable(dac_b)));
    a_r6_now_b: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && frm.load == LD_NOW && frm.chan == 1'b1) |=> (dac_b == $past(frm.code) && $stable(dac_a)));

    // R7: joint update puts the new code on the selected channel
    a_r7_all_a: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && frm.load == LD_ALL && frm.chan == 1'b0) |=> (dac_a == $past(frm.code)));
    a_r7_all_b: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && frm.load == LD_ALL && frm.chan == 1'b1) |=> (dac_b == $past(frm.code)));

    // R9: power mode follows the selected channel
    a_r9_pwr_a: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && frm.chan == 1'b0) |=> (pwr_a == $past(frm.pwr) && $stable(pwr_b)));
    a_r9_pwr_b: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && frm.chan == 1'b1) |=> (pwr_b == $past(frm.pwr) && $stable(pwr_a)));
endmodule

bind dac2_serial_rx dac2_serial_rx_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .fs_s    (fs_s),
    .frm_vld (frm_vld),
    .frm     (frm),
    .dac_a   (dac_a_o),
    .dac_b   (dac_b_o),
    .pwr_a   (pwr_a_o),
    .pwr_b   (pwr_b_o)
);

// File: tb/dac2_serial_rx_tb.sv
module dac2_serial_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_n = 1'b1;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic [15:0] dac_a, dac_b;
    logic [1:0]  pwr_a, pwr_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    dac2_serial_rx dut_i (
        .clk      (clk),
        .rst      (rst),
        .sync_n_i (sync_n),
        .sclk_i   (sclk),
        .din_i    (din),
        .dac_a_o  (dac_a),
        .dac_b_o  (dac_b),
        .pwr_a_o  (pwr_a),
        .pwr_b_o  (pwr_b)
    );

    // word, expected dac_a, dac_b, pwr_a, pwr_b after the word
    // word bits: 23:22 rsv, 21:20 load, 19 rsv, 18 chan, 17:16 pwr, 15:0 code
    localparam logic [59:0] VEC [8] = '{
        {24'h00_1234, 16'h0000, 16'h0000, 2'd0, 2'd0}, // R5 R8: buffer A only
        {24'h34_ABCD, 16'h1234, 16'hABCD, 2'd0, 2'd0}, // R7: B new, A from buffer
        {24'h11_5555, 16'h5555, 16'hABCD, 2'd1, 2'd0}, // R6 R9: A now, pwr A 01
        {24'h16_0F0F, 16'h5555, 16'h0F0F, 2'd1, 2'd2}, // R6 R8 R9: B now, pwr B 10
        {24'hEB_FFFF, 16'h5555, 16'h0F0F, 2'd3, 2'd2}, // R5 R10: load 10, rsv set
        {24'hFC_8001, 16'hFFFF, 16'h8001, 2'd3, 2'd0}, // R7 R10: joint, rsv set
        {24'h04_7777, 16'hFFFF, 16'h8001, 2'd3, 2'd0}, // R5: buffer B only
        {24'h30_0001, 16'h0001, 16'h7777, 2'd0, 2'd0}  // R7: A new, B from buffer
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [15:0] ea, input logic [15:0] eb,
                           input logic [1:0] pa, input logic [1:0] pb);
        chk({tag, " dac_a"}, dac_a, ea);
        chk({tag, " dac_b"}, dac_b, eb);
        chk({tag, " pwr_a"}, {14'd0, pwr_a}, {14'd0, pa});
        chk({tag, " pwr_b"}, {14'd0, pwr_b}, {14'd0, pb});
    endtask

    // send nbits of w (MSB first) then extra clocks of ones, half = clk cycles per sclk phase
    task automatic send(input logic [23:0] w, input int nbits, input int extra, input int half);
        sync_n = 1'b0;
        tick(half);
        for (int i = 0; i < nbits; i++) begin
            din = w[23-i];
            tick(half); sclk = 1'b0;
            tick(half); sclk = 1'b1;
        end
        for (int i = 0; i < extra; i++) begin
            din = 1'b1;
            tick(half); sclk = 1'b0;
            tick(half); sclk = 1'b1;
        end
        tick(half);
        sync_n = 1'b1;
        tick(8);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog got=running exp=finished");
        report();
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(4);
        chk_all("R2 reset", 16'h0000, 16'h0000, 2'd0, 2'd0);

        // R1: table of full frames at 8 clocks per serial bit
        for (int v = 0; v < 8; v++) begin
            send(VEC[v][59:36], 24, 0, 4);
            chk_all($sformatf("R1 vec%0d", v), VEC[v][35:20], VEC[v][19:4], VEC[v][3:2], VEC[v][1:0]);
        end

        // R3: truncated frames change nothing
        send(24'h11_9999, 10, 0, 4);
        chk_all("R3 cut10", 16'h0001, 16'h7777, 2'd0, 2'd0);
        send(24'h16_9999, 23, 0, 4);
        chk_all("R3 cut23", 16'h0001, 16'h7777, 2'd0, 2'd0);
        // R3: next full frame aligned from bit zero
        send(24'h11_2222, 24, 0, 4);
        chk_all("R3 after cut", 16'h2222, 16'h7777, 2'd1, 2'd0);

        // R4: extra clocks of ones ignored
        send(24'h16_3C3C, 24, 9, 4);
        chk_all("R4 extra", 16'h2222, 16'h3C3C, 2'd1, 2'd2);
        send(24'h10_0BAD, 24, 0, 4);
        chk_all("R4 next", 16'h0BAD, 16'h3C3C, 2'd0, 2'd2);

        // R11: serial clock at one quarter of system clock
        send(24'h17_4321, 24, 0, 2);
        chk_all("R11 fast", 16'h0BAD, 16'h4321, 2'd0, 2'd3);

        // R2: mid-run reset, then buffer B must read zero on a joint update
        @(negedge clk); rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(4);
        chk_all("R2 rerst", 16'h0000, 16'h0000, 2'd0, 2'd0);
        send(24'h30_0AAA, 24, 0, 4);
        chk_all("R2 buf zero", 16'h0AAA, 16'h0000, 2'd0, 2'd0);

        report();
    end
endmodule